// File: doc/BRIEF.md
# Bit-Angle-Modulated LED Layer Driver

This block refreshes one layer at a time of a cube of RGB LEDs that sit behind chains of external shift-register drivers. Each colour component has 8 bits of depth, shown as 8 bit planes. A plane is 64 bits per colour. The block fetches each plane from a frame buffer over a request/response handshake. It shifts the red, green and blue parts out on three serial lanes that share one shift clock, and then strobes a latch so that the drivers show the new plane. After the latch it holds that plane for a time set by the plane's weight. The hold for plane k is the programmable base count shifted left by k, in system clocks, so each hold is twice the one before.

The next plane is fetched and shifted while the current plane is held, so shifting adds nothing to the hold. The latch needs two things before it fires: the hold has expired, and all three lanes have finished shifting. When the shift finishes first, the hold sets the latch timing. When the hold ends first, the latch waits for the shift. After plane 7 the sequence goes on with plane 0 of the next layer, and the layer select output follows at that plane-0 latch.

Back-pressure rules. The block raises `req_valid` and keeps it high, with `req_layer` and `req_plane` unchanged, until the frame buffer raises `req_ready` in the same cycle. Once a request is accepted, the block raises `rsp_ready` and keeps it high until `rsp_valid` is seen in the same cycle. That cycle transfers `rsp_data`. The frame buffer may take as long as it needs on either phase; the latch of that plane is then delayed.

Top module: `bam_plane_driver`

## Requirements
- R1: While `rst_n` is low, `latch`, `sclk`, every bit of `sdo`, `layer_sel` and `rsp_ready` are 0.
- R2: Requests run through planes 0 to 7 of layer 0, then planes 0 to 7 of layer 1, and so on, wrapping from layer 7 to layer 0. While `req_valid` is high and `req_ready` is low, `req_valid`, `req_layer` and `req_plane` stay unchanged.
- R3: `rsp_ready` is high only between an accepted request and the accepted response, and never while a lane is shifting. Data moves only in a cycle with both `rsp_valid` and `rsp_ready` high.
- R4: Each lane sends its 64 bits most significant bit first, as four 16-bit words with bits 63..48 first. A receiver samples each bit on the rising edge of `sclk`. `sdo` changes only while `sclk` is low.
- R5: Lane 0 (red) carries `rsp_data[63:0]`, lane 1 (green) carries `rsp_data[127:64]` and lane 2 (blue) carries `rsp_data[191:128]`. All three lanes use the one `sclk`.
- R6: `sclk` stays high for exactly HALF_DIV system clocks per bit and is low whenever the block is not shifting.
- R7: `latch` is a one-cycle pulse. It is high only while `sclk` is low and no lane is shifting, and exactly 64 rising `sclk` edges happen between two successive latch pulses.
- R8: The interval between the latch of plane k and the next latch is at least `hold_base << k` clocks. It is exactly that many clocks when the next plane has finished shifting before the hold expires.
- R9: When the frame buffer stalls a response beyond the hold, the latch waits until the late plane has been fully shifted.
- R10: `layer_sel` changes only in a latch cycle, only at a plane-0 latch, and it always equals the layer of the plane being shown.
- R11: `hold_base` is sampled at the latch that starts a hold. A change between latches affects only later holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_base | input | 16 | Base hold count in clocks (plane 0 hold) |
| req_valid | output | 1 | Plane fetch request valid |
| req_ready | input | 1 | Frame buffer accepts the request |
| req_layer | output | 3 | Layer of the requested plane |
| req_plane | output | 3 | Bit plane index requested |
| rsp_valid | input | 1 | Frame buffer data valid |
| rsp_ready | output | 1 | Block ready to take plane data |
| rsp_data | input | 192 | Plane data, 64 bits per lane, red in the low bits |
| sclk | output | 1 | Shared shift clock |
| sdo | output | 3 | Serial data, bit 0 red, bit 1 green, bit 2 blue |
| latch | output | 1 | Driver latch strobe |
| layer_sel | output | 3 | Selected cube layer |

## Verification
The hardest case to reach is the race between the hold and the shift in each direction. In one case the latch must land exactly on the hold boundary. In the other a slow or stalled plane must push the latch out past the hold. The stimulus covers both. A base of 20 makes planes 0 to 3 shift-bound and planes 4 to 7 hold-bound. Part way through a layer, the base drops to 3, which makes nearly every plane shift-bound. One response deep in a hold-bound plane is held back for 900 clocks, which pushes its latch well past the 640-clock hold. The run carries on across a layer wrap, so the plane-0 layer change is seen on both sides of the wrap.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic [1:0] {
    F_REQ   = 2'd0,
    F_WAIT  = 2'd1,
    F_SHIFT = 2'd2,
    F_READY = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/bam_lane.sv
module bam_lane #(
  parameter int LANE_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 shift,
  input  logic [LANE_BITS-1:0] din,
  output logic                 sdo
);
  logic [LANE_BITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[LANE_BITS-2:0], 1'b0};
  end

  assign sdo = sr[LANE_BITS-1];
endmodule

// File: rtl/bam_shift_ctrl.sv
module bam_shift_ctrl #(
  parameter int LANE_BITS = 64,
  parameter int HALF_DIV  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sclk,
  output logic shift,
  output logic done
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(LANE_BITS + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [BW-1:0] left;
  logic          sclk_q;
  logic          tick;

  assign tick  = active && (cnt == CW'(HALF_DIV - 1));
  assign shift = tick && sclk_q;
  assign done  = shift && (left == BW'(1));
  assign busy  = active;
  assign sclk  = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      left   <= '0;
      sclk_q <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      left   <= BW'(LANE_BITS);
      sclk_q <= 1'b0;
    end else if (active) begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (tick) sclk_q <= ~sclk_q;
      if (shift) begin
        left <= left - BW'(1);
        if (left == BW'(1)) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bam_hold_timer.sv
module bam_hold_timer #(
  parameter int CW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= (len == '0) ? '0 : len - CW'(1);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bam_plane_driver.sv
module bam_plane_driver #(
  parameter int LANES     = 3,
  parameter int LANE_BITS = 64,
  parameter int PLANES    = 8,
  parameter int LAYERS    = 8,
  parameter int HALF_DIV  = 2,
  parameter int HOLD_W    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [HOLD_W-1:0]            hold_base,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [$clog2(LAYERS)-1:0]    req_layer,
  output logic [$clog2(PLANES)-1:0]    req_plane,
  input  logic                         rsp_valid,
  output logic                         rsp_ready,
  input  logic [LANES*LANE_BITS-1:0]   rsp_data,
  output logic                         sclk,
  output logic [LANES-1:0]             sdo,
  output logic                         latch,
  output logic [$clog2(LAYERS)-1:0]    layer_sel
);
  import bam_pkg::*;

  localparam int PW = $clog2(PLANES);
  localparam int LYW = $clog2(LAYERS);
  localparam int CW = HOLD_W + PLANES - 1;
  localparam logic [PW-1:0]  LAST_PLANE = PW'(PLANES - 1);
  localparam logic [LYW-1:0] LAST_LAYER = LYW'(LAYERS - 1);

  fetch_state_e   st;
  logic [PW-1:0]  pend_plane;
  logic [LYW-1:0] pend_layer;
  logic [LYW-1:0] layer_q;
  logic           latch_q;
  logic           accept;
  logic           sh_busy;
  logic           sh_shift;
  logic           sh_done;
  logic           hold_exp;
  logic           fire;
  logic [CW-1:0]  hold_len;

  assign req_valid = (st == F_REQ);
  assign rsp_ready = (st == F_WAIT);
  assign req_layer = pend_layer;
  assign req_plane = pend_plane;
  assign accept    = rsp_ready && rsp_valid;
  assign fire      = (st == F_READY) && hold_exp && !sh_busy;
  assign hold_len  = CW'(hold_base) << pend_plane;
  assign latch     = latch_q;
  assign layer_sel = layer_q;

  bam_shift_ctrl #(.LANE_BITS(LANE_BITS), .HALF_DIV(HALF_DIV)) u_sctl (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .busy(sh_busy), .sclk(sclk), .shift(sh_shift), .done(sh_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bam_lane #(.LANE_BITS(LANE_BITS)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(accept), .shift(sh_shift),
      .din(rsp_data[g*LANE_BITS +: LANE_BITS]), .sdo(sdo[g])
    );
  end

  bam_hold_timer #(.CW(CW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(fire), .len(hold_len), .expired(hold_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= F_REQ;
      pend_plane <= '0;
      pend_layer <= '0;
      layer_q    <= '0;
      latch_q    <= 1'b0;
    end else begin
      latch_q <= fire;
      unique case (st)
        F_REQ:   if (req_ready) st <= F_WAIT;
        F_WAIT:  if (rsp_valid) st <= F_SHIFT;
        F_SHIFT: if (sh_done)   st <= F_READY;
        F_READY: if (fire) begin
          st <= F_REQ;
          if (pend_plane == '0) layer_q <= pend_layer;
          if (pend_plane == LAST_PLANE) begin
            pend_plane <= '0;
            pend_layer <= (pend_layer == LAST_LAYER) ? '0 : pend_layer + LYW'(1);
          end else begin
            pend_plane <= pend_plane + PW'(1);
          end
        end
        default: st <= F_REQ;
      endcase
    end
  end
endmodule

// File: rtl/bam_plane_driver_chk.sv
module bam_plane_driver_chk #(
  parameter int LANES  = 3,
  parameter int PLANES = 8,
  parameter int LAYERS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      latch,
  input logic                      sclk,
  input logic [LANES-1:0]          sdo,
  input logic [$clog2(LAYERS)-1:0] layer_sel,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [$clog2(LAYERS)-1:0] req_layer,
  input logic [$clog2(PLANES)-1:0] req_plane,
  input logic                      rsp_ready,
  input logic                      sh_busy
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_layer) && $stable(req_plane)));

  a_r3_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !sh_busy);

  a_r4_sdo_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> !sclk);

  a_r6_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> !sclk);

  a_r7_latch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> (!sclk && !sh_busy));

  a_r7_latch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !latch);

  a_r10_layer_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(layer_sel) |-> latch);
endmodule

bind bam_plane_driver bam_plane_driver_chk #(
  .LANES(LANES), .PLANES(PLANES), .LAYERS(LAYERS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .latch(latch), .sclk(sclk), .sdo(sdo),
  .layer_sel(layer_sel), .req_valid(req_valid), .req_ready(req_ready),
  .req_layer(req_layer), .req_plane(req_plane), .rsp_ready(rsp_ready),
  .sh_busy(sh_busy)
);

// File: tb/sim_bam_plane_driver.sv
module sim_bam_plane_driver;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int STALL_REQ  = 22;
  localparam int STALL_CYC  = 900;
  localparam int END_LATCH  = 75;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  hold_base = 16'd20;
  logic         req_valid, req_ready = 1'b0;
  logic [2:0]   req_layer, req_plane;
  logic         rsp_valid = 1'b0, rsp_ready;
  logic [191:0] rsp_data = '0;
  logic         sclk, latch;
  logic [2:0]   sdo, layer_sel;

  int checks = 0, fails = 0;
  int cyc = 0, latches = 0;
  bit finished = 0;

  bam_plane_driver #(.HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_base(hold_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_layer(req_layer), .req_plane(req_plane),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sclk(sclk), .sdo(sdo), .latch(latch), .layer_sel(layer_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] pat(int layer, int plane, int lane);
    logic [63:0] x;
    x = 64'h9E3779B97F4A7C15 * 64'(layer * 8 + plane + 1);
    x = x ^ (x >> 29) ^ (64'(lane + 1) << 41) ^ 64'(lane * 7);
    return x;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // frame buffer model
  initial begin
    int rq = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (req_valid) begin
        // R2: request order
        chk(req_layer == 3'((rq / 8) % 8) && req_plane == 3'(rq % 8), "R2", "request index",
            {58'd0, req_layer, req_plane}, 64'(((rq / 8) % 8) * 8 + rq % 8));
        repeat (rq % 3) begin
          @(negedge clk);
          chk(req_valid && req_layer == 3'((rq / 8) % 8), "R2", "request held", 64'(req_valid), 64'd1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        // R3: not ready before response offered after delay
        repeat ((rq == STALL_REQ) ? STALL_CYC : (rq % 4)) @(negedge clk);
        rsp_data  = {pat((rq / 8) % 8, rq % 8, 2), pat((rq / 8) % 8, rq % 8, 1), pat((rq / 8) % 8, rq % 8, 0)};
        rsp_valid = 1'b1;
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(!rsp_ready, "R3", "ready drops after transfer", 64'(rsp_ready), 64'd0);
        rq++;
      end
    end
  end

  // output monitor
  initial begin
    logic [63:0] cap [3];
    int bits = 0, hi_run = 0, last_rise = 0, last_latch = 0, prev_n = 0;
    bit prev_sclk = 0;
    logic [2:0] prev_layer = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (sclk && !prev_sclk) begin
        for (int l = 0; l < 3; l++) cap[l] = {cap[l][62:0], sdo[l]};
        bits++;
        last_rise = cyc;
      end
      if (sclk) hi_run++;
      else if (prev_sclk) begin
        chk(hi_run == HALF_DIV, "R6", "sclk high time", 64'(hi_run), 64'(HALF_DIV));
        hi_run = 0;
      end
      prev_sclk = sclk;
      if (layer_sel != prev_layer && !latch)
        chk(0, "R10", "layer change outside latch", 64'(layer_sel), 64'(prev_layer));
      prev_layer = layer_sel;
      if (latch) begin
        int lay, pl, iv;
        lay = (latches / 8) % 8;
        pl  = latches % 8;
        chk(bits == 64, "R7", "sclk edges per plane", 64'(bits), 64'd64);
        for (int l = 0; l < 3; l++)
          chk(cap[l] == pat(lay, pl, l), (l == 0) ? "R4" : "R5", $sformatf("lane %0d plane %0d", l, latches),
              cap[l], pat(lay, pl, l));
        chk(layer_sel == 3'(lay), "R10", "layer select", 64'(layer_sel), 64'(lay));
        if (latches > 0) begin
          iv = cyc - last_latch;
          chk(iv >= prev_n, "R8", $sformatf("hold min at latch %0d", latches), 64'(iv), 64'(prev_n));
          if (last_rise + 2 * HALF_DIV + 4 < last_latch + prev_n)
            chk(iv == prev_n, "R8", $sformatf("exact hold at latch %0d", latches), 64'(iv), 64'(prev_n));
          if (latches == STALL_REQ)
            chk(iv >= STALL_CYC + 64 * 2 * HALF_DIV, "R9", "stalled plane delays latch",
                64'(iv), 64'(STALL_CYC + 64 * 2 * HALF_DIV));
        end
        // R11: hold taken from base at this latch
        prev_n     = int'(hold_base) << pl;
        last_latch = cyc;
        bits       = 0;
        latches++;
      end
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(latch == 0 && sclk == 0 && sdo == 0, "R1", "serial outputs in reset", {61'd0, latch, sclk, |sdo}, 64'd0);
    chk(layer_sel == 0 && rsp_ready == 0, "R1", "layer and ready in reset", {60'd0, layer_sel, rsp_ready}, 64'd0);
    rst_n = 1'b1;
    while (latches < 36) @(negedge clk);
    do @(negedge clk); while (latch);
    #1 hold_base = 16'd3;
    while (latches < END_LATCH) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, latches %0d expected %0d", latches, END_LATCH);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule